// File: doc/BRIEF.md
# Oversampling Serial Receive Engine with Per-Character Error Capture

This block turns an asynchronous serial input into parallel characters. A baud-rate enable strobe at sixteen times the bit rate paces it. While it waits, the line idles high. The first low level it sees on an enabled tick arms a sub-bit counter. Eight ticks later the receiver looks at the line again to confirm the start bit. A glitch that has already gone high by then is dropped, and the receiver returns to waiting. Once the start bit is confirmed, the data bits, an optional parity bit and the stop bit are each sampled once, sixteen ticks apart, close to the centre of each bit cell.

When the stop bit has been sampled, the block emits a 12-bit word for one clock cycle, together with a write strobe meant for a receive queue. The low byte holds the character. The upper nibble holds the error flags of that character. Character length and parity mode come from static configuration inputs. A break, meaning a line that stays low for a whole frame, is reported once. After a break the receiver does not arm again until the line has gone high.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, and until the first character ends, `rx_wr` is 0 and `rx_word` is 0.
- R2: The start bit is checked on the eighth enabled tick after the tick that first saw the line low. If the line is high at that check, no character is produced.
- R3: Data bits are taken least significant bit first, one every 16 enabled ticks after the start check, and appear in `rx_word[7:0]`.
- R4: `cfg_len` selects 5, 6, 7 or 8 data bits (encodings 0, 1, 2, 3). Bits of `rx_word[7:0]` above the selected length are 0.
- R5: With `cfg_par_en`=1 and `cfg_par_odd`=0, a parity bit follows the data. `rx_word[9]` is set when data plus parity hold an odd number of ones.
- R6: With `cfg_par_en`=1 and `cfg_par_odd`=1, `rx_word[9]` is set when data plus parity hold an even number of ones.
- R7: A low stop-bit sample sets the framing flag `rx_word[8]`.
- R8: A frame whose data, parity and stop samples are all low is a break. It is reported as `rx_word` = 0x500 (break flag bit 10 and framing flag set, parity flag clear, data zero). No further character starts until the line has returned high.
- R9: The overrun position `rx_word[11]` is always 0. The queue fills it in.
- R10: Each character produces exactly one single-cycle `rx_wr` pulse. `rx_word` changes only in that cycle.
- R11: Sampling advances only on cycles with `baud16_en`=1. An input held for a given number of enabled ticks decodes the same at any tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud16_en | input | 1 | One-cycle enable at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| cfg_len | input | 2 | Data length code: 0..3 selects 5..8 bits |
| cfg_par_en | input | 1 | 1 adds a parity bit after the data |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| rx_word | output | 12 | {overrun(0), break, parity err, framing err, data[7:0]} |
| rx_wr | output | 1 | One-cycle write strobe toward the receive queue |

## Verification
The checker assumes that the configuration inputs do not change while a frame is in flight, because the upper-bit check reads `cfg_len` at the moment the word is written. It also assumes that enabled ticks arrive at most once per clock and that characters are at least a bit time apart. The stimulus changes length and parity only in idle gaps between frames. It spaces ticks evenly, every fourth clock, and holds each bit for exactly sixteen ticks, so every sample falls well inside its bit cell.

// File: rtl/uart_rx_pkg.sv
// Package: shared types and field positions for the serial receive engine.
// Assumes an 8-bit maximum character and a 2-bit length code (5..8 bits).
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK
    } rx_state_e;

    localparam int FLAG_OVR = 11;
    localparam int FLAG_BRK = 10;
    localparam int FLAG_PAR = 9;
    localparam int FLAG_FRM = 8;

    // Map the 2-bit length code onto a bit count of 5..8.
    function automatic logic [3:0] len_from_code(input logic [1:0] code);
        return 4'(code) + 4'd5;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
// Module: multi-stage synchronizer for the asynchronous serial input.
// Assumes STAGES >= 2; resets to the idle (high) line level.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);

    logic [STAGES-1:0] pipe_q;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pipe_q <= '1;
        else
            pipe_q <= {pipe_q[STAGES-2:0], d_async};
    end

    assign d_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/uart_rx_timer.sv
// Module: sub-bit tick counter. It flags the mid-start check and each
// following bit-centre sample. Assumes OS is even and at least 4.
module uart_rx_timer #(
    parameter int OS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    output logic at_mid,
    output logic at_bit
);

    localparam int CW   = $clog2(OS);
    localparam int HALF = OS / 2;

    logic [CW-1:0] cnt_q;

    // Count enabled ticks, wrapping every OS ticks; clear takes precedence.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= (cnt_q == CW'(OS - 1)) ? '0 : cnt_q + 1'b1;
    end

    assign at_mid = tick && (cnt_q == CW'(HALF - 1));
    assign at_bit = tick && (cnt_q == CW'(OS - 1));

endmodule

// File: rtl/uart_rx_core.sv
// Module: oversampling serial receiver. It confirms the start bit at
// mid-bit, assembles 5..8 data bits LSB first, checks optional parity and
// the stop bit, detects break, and strobes one flagged word per character.
// Assumes cfg_* are stable for the whole frame and that baud16_en pulses
// for a single cycle.
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud16_en,
    input  logic              rx_line,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    output logic [DATA_W+3:0] rx_word,
    output logic              rx_wr
);

    localparam int IDX_W = $clog2(DATA_W);

    rx_state_e         state_q;
    logic              line_s;
    logic              at_mid, at_bit;
    logic              tmr_clear;
    logic [DATA_W-1:0] data_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic              par_acc_q;
    logic              all_low_q;
    logic              is_brk;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_line),
        .d_sync  (line_s)
    );

    uart_rx_timer #(.OS(OVERSAMPLE)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (baud16_en),
        .clear  (tmr_clear),
        .at_mid (at_mid),
        .at_bit (at_bit)
    );

    // Hold the counter at zero while idle and restart it at the start check.
    always_comb begin
        tmr_clear = (state_q == ST_IDLE) || ((state_q == ST_START) && at_mid);
    end

    // Index of the final data bit for the configured length.
    always_comb begin
        last_idx = IDX_W'(len_from_code(cfg_len) - 4'd1);
    end

    // Break: every earlier sample low and the stop sample low as well.
    always_comb begin
        is_brk = all_low_q && !line_s;
    end

    // Frame sequencing, data assembly and word emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            data_q    <= '0;
            idx_q     <= '0;
            par_acc_q <= 1'b0;
            all_low_q <= 1'b0;
            rx_word   <= '0;
            rx_wr     <= 1'b0;
        end else begin
            rx_wr <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (baud16_en && !line_s)
                        state_q <= ST_START;
                end
                ST_START: begin
                    if (at_mid) begin
                        if (line_s) begin
                            state_q <= ST_IDLE;
                        end else begin
                            state_q   <= ST_DATA;
                            data_q    <= '0;
                            idx_q     <= '0;
                            par_acc_q <= 1'b0;
                            all_low_q <= 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (at_bit) begin
                        data_q[idx_q] <= line_s;
                        par_acc_q     <= par_acc_q ^ line_s;
                        all_low_q     <= all_low_q & ~line_s;
                        if (idx_q == last_idx)
                            state_q <= cfg_par_en ? ST_PAR : ST_STOP;
                        else
                            idx_q <= idx_q + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_bit) begin
                        par_acc_q <= par_acc_q ^ line_s;
                        all_low_q <= all_low_q & ~line_s;
                        state_q   <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (at_bit) begin
                        rx_wr                  <= 1'b1;
                        rx_word[DATA_W-1:0]    <= data_q;
                        rx_word[DATA_W+3]      <= 1'b0;
                        rx_word[DATA_W+2]      <= is_brk;
                        rx_word[DATA_W+1]      <= !is_brk && cfg_par_en
                                                  && (par_acc_q ^ cfg_par_odd);
                        rx_word[DATA_W]        <= !line_s;
                        state_q                <= is_brk ? ST_BRK : ST_IDLE;
                    end
                end
                ST_BRK: begin
                    if (baud16_en && line_s)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_core_chk.sv
// Module: property checker for uart_rx_core, attached by bind.
// Assumes cfg_len is stable while a frame is in flight.
module uart_rx_core_chk #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              baud16_en,
    input logic [1:0]        cfg_len,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_wr
);

    // R9: the overrun slot is never set by this block.
    assert_ovr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr |-> !rx_word[WORD_W-1]);

    // R10: the write strobe lasts one cycle.
    assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr |=> !rx_wr);

    // R10: the output word holds between strobes.
    assert_word_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_wr |-> $stable(rx_word));

    // R8: a break word carries zero data and the framing flag, not parity.
    assert_brk_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wr && rx_word[WORD_W-2]) |->
            (rx_word[WORD_W-5:0] == '0 && rx_word[WORD_W-4] && !rx_word[WORD_W-3]));

    // R4: with 5-bit characters the three upper data bits stay clear.
    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wr && cfg_len == 2'd0) |-> rx_word[7:5] == 3'b000);

    // R11: a word is emitted only as the result of an enabled tick.
    assert_wr_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr |-> $past(baud16_en));

endmodule

bind uart_rx_core uart_rx_core_chk #(.WORD_W(12)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud16_en (baud16_en),
    .cfg_len   (cfg_len),
    .rx_word   (rx_word),
    .rx_wr     (rx_wr)
);

// File: tb/tb_uart_rx_core.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected words, the monitor pops and
// compares them on every write strobe.
module tb_uart_rx_core;

    localparam int DIV = 4;             // clocks per enabled tick
    localparam int BIT_CYC = 16 * DIV;  // clocks per bit cell

    typedef struct {
        logic [11:0] word;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud16_en = 1'b0;
    logic        rx_line = 1'b1;
    logic [1:0]  cfg_len = 2'd3;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic [11:0] rx_word;
    logic        rx_wr;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t exp_q[$];
    int   div_cnt = 0;

    always #2 clk = ~clk;

    // Tick generator: one enable cycle every DIV clocks.
    always @(posedge clk) begin
        div_cnt   <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
        baud16_en <= (div_cnt == DIV - 1);
    end

    uart_rx_core dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud16_en   (baud16_en),
        .rx_line     (rx_line),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .rx_word     (rx_word),
        .rx_wr       (rx_wr)
    );

    task automatic check(input bit ok, input string tag, input logic [11:0] act,
                         input logic [11:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h", tag, act, expv);
        end
    endtask

    // Monitor: compare each strobed word with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rx_wr) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R8 unexpected write", rx_word, 12'h000);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rx_word === e.word, e.tag, rx_word, e.word);
            end
        end
    end

    task automatic hold(input logic v, input int cells);
        rx_line = v;
        repeat (cells * BIT_CYC) @(negedge clk);
    endtask

    // Driver: one frame; flip_par corrupts parity, stop_v is the stop level.
    task automatic send(input logic [7:0] d, input int nbits, input bit pen,
                        input bit podd, input bit flip_par, input bit stop_v,
                        input string tag);
        logic [7:0] m;
        logic       pbit;
        exp_t       e;
        cfg_len     = 2'(nbits - 5);
        cfg_par_en  = pen;
        cfg_par_odd = podd;
        hold(1'b1, 2);
        m    = d & 8'((1 << nbits) - 1);
        pbit = (^m) ^ podd ^ flip_par;
        e.word = {1'b0, 1'b0, pen & flip_par, ~stop_v, m};
        e.tag  = tag;
        exp_q.push_back(e);
        hold(1'b0, 1);
        for (int i = 0; i < nbits; i++) hold(d[i], 1);
        if (pen) hold(pbit, 1);
        hold(stop_v, 1);
        hold(1'b1, 2);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(rx_wr === 1'b0 && rx_word === 12'h000, "R1 reset", rx_word, 12'h000);
        rst_n = 1'b1;
        repeat (3 * BIT_CYC) @(negedge clk);
        check(rx_wr === 1'b0 && rx_word === 12'h000, "R1 idle after reset", rx_word, 12'h000);

        send(8'hA5, 8, 0, 0, 0, 1, "R3 8N1 0xA5");
        send(8'h3C, 8, 0, 0, 0, 1, "R3 R11 8N1 0x3C");
        send(8'hFF, 5, 0, 0, 0, 1, "R4 5-bit upper zero");
        send(8'hEA, 6, 0, 0, 0, 1, "R4 6-bit");
        send(8'h55, 7, 0, 0, 0, 1, "R4 7-bit");
        send(8'h37, 8, 1, 0, 0, 1, "R5 even parity good");
        send(8'h37, 8, 1, 0, 1, 1, "R5 even parity bad");
        send(8'h81, 8, 1, 1, 0, 1, "R6 odd parity good");
        send(8'h81, 8, 1, 1, 1, 1, "R6 odd parity bad");
        send(8'h5A, 8, 0, 0, 0, 0, "R7 framing error");
        send(8'h12, 7, 1, 1, 0, 0, "R7 framing with parity");

        // R2: low glitch of 4 ticks; no word expected
        cfg_len = 2'd3; cfg_par_en = 1'b0;
        hold(1'b1, 1);
        rx_line = 1'b0;
        repeat (4 * DIV) @(negedge clk);
        hold(1'b1, 3);
        check(exp_q.size() == 0, "R2 false start ignored", 12'(exp_q.size()), 12'h000);
        send(8'hC3, 8, 0, 0, 0, 1, "R2 frame after glitch");

        // R8: break held for 12 bit cells, one word only, then re-arm
        begin
            exp_t e;
            e.word = 12'h500;
            e.tag  = "R8 break word";
            exp_q.push_back(e);
        end
        hold(1'b0, 12);
        check(exp_q.size() == 0, "R8 break reported once", 12'(exp_q.size()), 12'h000);
        hold(1'b1, 2);
        send(8'h96, 8, 0, 0, 0, 1, "R8 re-arm after break");

        hold(1'b1, 2);
        // R10: every expected word arrived, with no extra strobes
        check(exp_q.size() == 0, "R10 all words strobed", 12'(exp_q.size()), 12'h000);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule